// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block sits between two 16-bit buses, called A and B. It holds one storage register for each direction of transfer. The word is split into two 8-bit halves. For each half and each direction, three active-low or strobe controls decide three things: whether the half accepts a new word, when it captures it, and whether the stored value is driven onto the far bus. The two halves can work as two independent byte-wide transceivers, or the controls can be tied together so that the halves act as one 16-bit transceiver.

Everything runs on one system clock. The enable, strobe and output-enable pins are asynchronous to it, so each passes through a two-stage synchronizer. A half captures when the synchronized value of "strobe high and enable low" goes from 0 to 1. Because the enable gates the strobe, a falling enable while the strobe is already high also counts as a capture edge, and the block keeps this behaviour on purpose. The data word is taken from the bus input in the system-clock cycle of the capture. Pad drivers are represented by a data vector plus one drive-enable bit per half.

The bus data ports have no valid/ready handshake. They are level-sampled buses, and the capture strobe is the only qualifier. Nothing can push back on them.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: While the synchronous active-high reset is applied, and on the cycle after it, both stored words read zero on `a_out` and `b_out`, and every bit of `a_oe` and `b_oe` is 0.
- R2: For half h of the A-to-B path, the stored byte `b_out[8h+7:8h]` loads `a_in[8h+7:8h]` at the clock edge on which the synchronized `(ab_stb[h] & ~ab_ce_n[h])` goes from 0 to 1. When the controls change between edges, this is the third rising edge after the change. The new value is visible after that edge.
- R3: When no capture edge occurs, a half's stored byte keeps its value. This holds whether the strobe is steadily low or steadily high, whether the bus data changes, and whether the output enables toggle.
- R4: `b_oe[h]` is 1 exactly when the synchronized `ab_ce_n[h]` and `ab_oe_n[h]` are both 0, two rising edges after the inputs settle. If either is 1, the half is not driven. Bit h of an enable vector covers data bits 8h+7 down to 8h.
- R5: A rising strobe while the half's `ce_n` is 1 captures nothing.
- R6: With the strobe held at 1, a 1-to-0 transition of the half's `ce_n` is a capture edge. The byte loads on the third rising edge after the transition.
- R7: The B-to-A path behaves like R2, R4 and R5, using `ba_ce_n`, `ba_stb`, `ba_oe_n` and `b_in`. It drives `a_out` and `a_oe`.
- R8: The controls of one half have no effect on the stored byte or the drive enable of the other half.
- R9: Activity in one direction has no effect on the stored word or the drive enables of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Value present on the A bus |
| a_out | output | 16 | Stored B-to-A word, driven toward A |
| a_oe | output | 2 | Per-half drive enable toward A |
| b_in | input | 16 | Value present on the B bus |
| b_out | output | 16 | Stored A-to-B word, driven toward B |
| b_oe | output | 2 | Per-half drive enable toward B |
| ab_ce_n | input | 2 | Per-half A-to-B enable, active low |
| ab_stb | input | 2 | Per-half A-to-B capture strobe |
| ab_oe_n | input | 2 | Per-half A-to-B output enable, active low |
| ba_ce_n | input | 2 | Per-half B-to-A enable, active low |
| ba_stb | input | 2 | Per-half B-to-A capture strobe |
| ba_oe_n | input | 2 | Per-half B-to-A output enable, active low |

## Verification
The bench targets the enable falling while the strobe is high. A design that edge-detects the raw strobe alone would miss that capture and keep the old byte. It also raises the strobe with the enable high, where a design that ignores the gate would load data it should refuse. It toggles only the output enables and changes bus data with no strobe, so a design that reloads on level, or clears its register when the drive is removed, shows a wrong byte. Long random control and data sequences on all four lanes at once check capture latency against a bench model. A lane wired to the wrong half, or a capture one cycle early or late, shows up there as a mismatched byte.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic ce_n;
    logic stb;
    logic oe_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, stb: 1'b0, oe_n: 1'b1};
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RST_VAL;
      else if (s == 0) pipe[s] <= d;
      else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else prev <= level;
  end

  assign rise = level & ~prev;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl_raw,
  input  logic [HALF_W-1:0] din,
  output logic [HALF_W-1:0] dout,
  output logic              drive,
  output logic              cap
);
  logic [CTL_W-1:0] ctl_bits;
  ctl_t             ctl_s;
  logic             gate;
  logic [HALF_W-1:0] store_q;

  xcvr_sync #(.W(CTL_W), .STAGES(STAGES), .RST_VAL(CTL_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_bits)
  );

  assign ctl_s = ctl_t'(ctl_bits);
  // enable gates the strobe: a falling enable under a high strobe is an edge
  assign gate  = ctl_s.stb & ~ctl_s.ce_n;

  xcvr_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (gate),
    .rise  (cap)
  );

  always_ff @(posedge clk) begin
    if (rst) store_q <= '0;
    else if (cap) store_q <= din;
  end

  assign dout  = store_q;
  assign drive = ~ctl_s.ce_n & ~ctl_s.oe_n;
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int NUM_HALVES = 2,
  parameter int SYNC_STAGES = 2,
  localparam int W = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          a_in,
  output logic [W-1:0]          a_out,
  output logic [NUM_HALVES-1:0] a_oe,
  input  logic [W-1:0]          b_in,
  output logic [W-1:0]          b_out,
  output logic [NUM_HALVES-1:0] b_oe,
  input  logic [NUM_HALVES-1:0] ab_ce_n,
  input  logic [NUM_HALVES-1:0] ab_stb,
  input  logic [NUM_HALVES-1:0] ab_oe_n,
  input  logic [NUM_HALVES-1:0] ba_ce_n,
  input  logic [NUM_HALVES-1:0] ba_stb,
  input  logic [NUM_HALVES-1:0] ba_oe_n
);
  logic [NUM_HALVES-1:0] ab_cap;
  logic [NUM_HALVES-1:0] ba_cap;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    ctl_t ab_ctl;
    ctl_t ba_ctl;

    assign ab_ctl = '{ce_n: ab_ce_n[h], stb: ab_stb[h], oe_n: ab_oe_n[h]};
    assign ba_ctl = '{ce_n: ba_ce_n[h], stb: ba_stb[h], oe_n: ba_oe_n[h]};

    xcvr_lane #(.HALF_W(HALF_W), .STAGES(SYNC_STAGES)) u_ab (
      .clk     (clk),
      .rst     (rst),
      .ctl_raw (ab_ctl),
      .din     (a_in[h*HALF_W +: HALF_W]),
      .dout    (b_out[h*HALF_W +: HALF_W]),
      .drive   (b_oe[h]),
      .cap     (ab_cap[h])
    );

    xcvr_lane #(.HALF_W(HALF_W), .STAGES(SYNC_STAGES)) u_ba (
      .clk     (clk),
      .rst     (rst),
      .ctl_raw (ba_ctl),
      .din     (b_in[h*HALF_W +: HALF_W]),
      .dout    (a_out[h*HALF_W +: HALF_W]),
      .drive   (a_oe[h]),
      .cap     (ba_cap[h])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int HALF_W = 8,
  parameter int NH = 2,
  localparam int W = HALF_W * NH
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  a_in,
  input logic [W-1:0]  b_in,
  input logic [W-1:0]  a_out,
  input logic [W-1:0]  b_out,
  input logic [NH-1:0] a_oe,
  input logic [NH-1:0] b_oe,
  input logic [NH-1:0] ab_cap,
  input logic [NH-1:0] ba_cap
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

  for (genvar h = 0; h < NH; h++) begin : g_h
    p_load_ab_r2: assert property (@(posedge clk) disable iff (rst)
      ab_cap[h] |=> b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]));
    p_load_ba_r7: assert property (@(posedge clk) disable iff (rst)
      ba_cap[h] |=> a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W]));
    // R3, R8, R9: a byte only moves after its own lane captured
    p_hold_ab_r3: assert property (@(posedge clk) disable iff (rst)
      !ab_cap[h] |=> $stable(b_out[h*HALF_W +: HALF_W]));
    p_hold_ba_r9: assert property (@(posedge clk) disable iff (rst)
      !ba_cap[h] |=> $stable(a_out[h*HALF_W +: HALF_W]));
    p_single_edge_r6: assert property (@(posedge clk) disable iff (rst)
      ab_cap[h] |=> !ab_cap[h]);
  end
endmodule

bind bidir_reg_xcvr xcvr_chk #(.HALF_W(HALF_W), .NH(NUM_HALVES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .a_in   (a_in),
  .b_in   (b_in),
  .a_out  (a_out),
  .b_out  (b_out),
  .a_oe   (a_oe),
  .b_oe   (b_oe),
  .ab_cap (ab_cap),
  .ba_cap (ba_cap)
);

// File: tb/tb_bidir_reg_xcvr.sv
`timescale 1ns/1ps
module tb_bidir_reg_xcvr;
  localparam int HW = 8;
  localparam int NH = 2;
  localparam int W  = HW * NH;
  localparam int NL = 2 * NH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic [NH-1:0] a_oe, b_oe;
  logic [NH-1:0] ab_ce_n = '1, ab_stb = '0, ab_oe_n = '1;
  logic [NH-1:0] ba_ce_n = '1, ba_stb = '0, ba_oe_n = '1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bidir_reg_xcvr dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_ce_n(ab_ce_n), .ab_stb(ab_stb), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_stb(ba_stb), .ba_oe_n(ba_oe_n)
  );

  // Reference model from the requirements; lane l<NH is A-to-B half l
  logic [2:0]    s1 [NL];
  logic [2:0]    s2 [NL];
  logic          gprev [NL];
  logic [HW-1:0] mreg [NL];

  function automatic logic [2:0] raw_ctl(int l);
    if (l < NH) return {ab_ce_n[l], ab_stb[l], ab_oe_n[l]};
    return {ba_ce_n[l-NH], ba_stb[l-NH], ba_oe_n[l-NH]};
  endfunction

  function automatic logic [HW-1:0] lane_din(int l);
    if (l < NH) return a_in[l*HW +: HW];
    return b_in[(l-NH)*HW +: HW];
  endfunction

  function automatic logic exp_oe(int l);
    return ~s2[l][2] & ~s2[l][0];
  endfunction

  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (rst) begin
        s1[l] = 3'b101; s2[l] = 3'b101; gprev[l] = 1'b0; mreg[l] = '0;
      end else begin
        logic g;
        g = s2[l][1] & ~s2[l][2];
        if (g & ~gprev[l]) mreg[l] = lane_din(l);
        gprev[l] = g;
        s2[l] = s1[l];
        s1[l] = raw_ctl(l);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_cmp();
    for (int h = 0; h < NH; h++) begin
      chk("R2 R3 R8 b_out", 32'(b_out[h*HW +: HW]), 32'(mreg[h]));
      chk("R7 R9 a_out",    32'(a_out[h*HW +: HW]), 32'(mreg[h+NH]));
      chk("R4 b_oe", 32'(b_oe[h]), 32'(exp_oe(h)));
      chk("R7 a_oe", 32'(a_oe[h]), 32'(exp_oe(h+NH)));
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    chk("R1 b_out", 32'(b_out), 0); chk("R1 b_oe", 32'(b_oe), 0);
    rst = 1'b0;
    step(1);
    chk("R1 a_out", 32'(a_out), 0); chk("R1 a_oe", 32'(a_oe), 0);

    // R2: capture low half A-to-B
    a_in = 16'hA55A; ab_ce_n[0] = 0; ab_oe_n[0] = 0;
    step(3);
    chk("R4 b_oe enabled", 32'(b_oe), 32'h1);
    ab_stb[0] = 1;
    step(2);
    chk("R2 not yet", 32'(b_out[7:0]), 0);
    step(1);
    chk("R2 captured", 32'(b_out[7:0]), 32'h5A);
    chk("R8 upper untouched", 32'(b_out[15:8]), 0);
    // R3: data change, strobe high steady then low
    a_in = 16'h1234; step(4);
    chk("R3 hold strobe high", 32'(b_out[7:0]), 32'h5A);
    ab_stb[0] = 0; step(4);
    chk("R3 hold strobe low", 32'(b_out[7:0]), 32'h5A);

    // R5: strobe rise with enable high
    ab_stb[1] = 1; step(4);
    chk("R5 blocked", 32'(b_out[15:8]), 0);
    chk("R4 b_oe1 off", 32'(b_oe[1]), 0);
    // R6: enable falls under high strobe
    a_in = 16'hC300; ab_ce_n[1] = 0; ab_oe_n[1] = 0;
    step(2);
    chk("R6 not yet", 32'(b_out[15:8]), 0);
    step(1);
    chk("R6 spurious capture", 32'(b_out[15:8]), 32'hC3);
    // R4: output enable off keeps data
    ab_oe_n[1] = 1; step(3);
    chk("R4 drive removed", 32'(b_oe), 32'h1);
    chk("R3 data kept", 32'(b_out), 32'hC35A);
    ab_oe_n[1] = 0; ab_ce_n[0] = 1; step(3);
    chk("R4 ce_n high disables", 32'(b_oe), 32'h2);

    // R7/R9: B-to-A both halves
    b_in = 16'h7E81; ba_ce_n = '0; ba_oe_n = '0; ba_stb = '1;
    step(4);
    chk("R7 a_out", 32'(a_out), 32'h7E81);
    chk("R7 a_oe", 32'(a_oe), 32'h3);
    chk("R9 b_out unchanged", 32'(b_out), 32'hC35A);
    chk("R9 b_oe unchanged", 32'(b_oe), 32'h2);
    model_cmp();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        int h;
        h = $urandom_range(0, NH-1);
        case ($urandom_range(0, 5))
          0: ab_ce_n[h] = ~ab_ce_n[h];
          1: ab_stb[h]  = ~ab_stb[h];
          2: ab_oe_n[h] = ~ab_oe_n[h];
          3: ba_ce_n[h] = ~ba_ce_n[h];
          4: ba_stb[h]  = ~ba_stb[h];
          default: ba_oe_n[h] = ~ba_oe_n[h];
        endcase
      end
      step(1);
      model_cmp();
    end

    // R1 mid-run reset
    rst = 1'b1; step(2);
    chk("R1 reset words", 32'({a_out, b_out}), 0);
    chk("R1 reset enables", 32'({a_oe, b_oe}), 0);
    rst = 1'b0; step(1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule